// File: doc/BRIEF.md
# Express Channel Source Launch Gate

This block sits in a router that may open an express virtual channel toward a node several hops away. Each cycle it takes at most one launch request carrying a desired hop length, plus a flag saying that virtual-channel and switch allocation have already been won. It then decides whether the flit goes out on an express channel of that length, drops back to a normal single-hop channel, or waits. For every hop length from 1 (normal) up to `LMAX` it keeps a credit counter for the buffers at the receiving router. Shorter bins get deeper counters. Credit returns arrive as one bit per bin and may come from as far as `LMAX` hops away.

Intermediate bypass routers that are being starved send a token. The token stops express launches from this source for the cycle in which it arrives and for the `BLOCK_CYC` cycles that follow. Normal launches go on as before during that window. Every granted express launch raises a lookahead strobe, which tells downstream bypass routers to set their switches ahead of the flit. The decision is registered, so grant, length and strobe all appear one cycle after the request.

Top module: `xvc_launch_gate`

## Requirements
- R1: After reset, grant and lookahead are 0. Every bin holds its full credit count, which is `BASE_DEPTH + LMAX - k` for hop length k. This leaves at least one reserved buffer in every bin.
- R2: A grant is issued only for a cycle in which both `req_valid` and `alloc_ok` are 1. Grant, grant length and lookahead appear on the clock edge that ends the request cycle.
- R3: A request with `req_len` from 2 to `LMAX` is granted at that length when the bin for that length holds a credit and express launches are not blocked.
- R4: When the express bin is empty or launches are blocked, the request is granted as a normal launch with `grant_len` = 1, provided the length-1 bin holds a credit. Otherwise nothing is granted.
- R5: A `req_len` of 1, 0 or any value above `LMAX` is a normal request. It is granted with length 1 only when the length-1 bin holds a credit.
- R6: Each grant uses one credit from the bin of the granted length. A bin with no credits grants nothing at its length until a credit comes back.
- R7: Bit k of `crd_ret` returns one credit to hop length k+1. A return to a full bin is dropped. A return and a launch in the same bin in the same cycle leave the count unchanged.
- R8: A `starve_tok` pulse blocks express grants in the cycle it arrives and in the next `BLOCK_CYC` cycles. Normal grants are not affected.
- R9: A token that arrives while a block is active restarts the full `BLOCK_CYC` window from that cycle.
- R10: `lookahead` is 1 in exactly those output cycles whose grant has length 2 or more, one cycle per express launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A flit wants to launch this cycle |
| req_len | input | $clog2(LMAX+1) | Desired hop length (2..LMAX express, otherwise normal) |
| alloc_ok | input | 1 | VC and switch allocation won for this flit |
| crd_ret | input | LMAX | Credit return, bit k for hop length k+1 |
| starve_tok | input | 1 | Starvation token from a bypass router |
| grant | output | 1 | Launch granted (registered) |
| grant_len | output | $clog2(LMAX+1) | Granted hop length, 1 for normal |
| lookahead | output | 1 | One-cycle strobe per express launch |

## Verification
Every result is due one clock edge after the request that causes it. The bench drives inputs at the falling edge and compares grant, length and strobe just after the next rising edge. Credit state and the block window take effect on that same edge, so the bench model updates its own credits and window counter at the edge and applies them to the following request. A token's window is counted from the token's own cycle through the next `BLOCK_CYC` request cycles. The directed checks land requests on the last blocked cycle and on the first free cycle.

// File: rtl/xvc_pkg.sv
// Package: shared helpers for the express launch gate.
// Assumes hop length 1 is the normal channel and 2..LMAX are express lengths.
package xvc_pkg;
    // Credit depth of the bin for a given hop length; shorter hops get more buffers.
    function automatic int bin_depth(input int hop, input int lmax, input int base);
        return base + lmax - hop;
    endfunction
endpackage

// File: rtl/xvc_credit_bin.sv
// Module: one credit counter for a single hop-length bin.
// Holds DEPTH credits at reset. A return to a full bin is dropped.
// Assumes take is asserted only while has_credit is 1.
module xvc_credit_bin #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret,
    input  logic          take,
    output logic [CW-1:0] cnt,
    output logic          has_credit
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // Count up on a return, down on a launch, hold when both happen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else begin
            case ({ret, take})
                2'b10: if (cnt != FULL) cnt <= cnt + 1'b1;
                2'b01: cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // A credit is available whenever the count is non-zero.
    always_comb has_credit = (cnt != '0);
endmodule

// File: rtl/xvc_block_timer.sv
// Module: starvation window timer.
// A token blocks express launches in its own cycle and the next P cycles.
// A token during an active window restarts it. Assumes P >= 1.
module xvc_block_timer #(
    parameter int P  = 6,
    parameter int PW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tok,
    output logic blocked
);
    logic [PW-1:0] remain;

    // Load the window on a token, otherwise count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (tok)            remain <= PW'(P);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    // Blocked while cycles remain, or in the cycle the token arrives.
    always_comb blocked = tok || (remain != '0);
endmodule

// File: rtl/xvc_pick.sv
// Module: combinational launch decision.
// Picks an express length, falls back to a normal hop, or grants nothing.
// Assumes has[k] reports a credit for hop length k+1.
module xvc_pick #(
    parameter int LMAX = 4,
    parameter int LW   = 3
) (
    input  logic            req_valid,
    input  logic            alloc_ok,
    input  logic [LW-1:0]   req_len,
    input  logic [LMAX-1:0] has,
    input  logic            blocked,
    output logic            go,
    output logic [LW-1:0]   go_len,
    output logic            go_x,
    output logic [LMAX-1:0] take
);
    logic want_x;
    logic x_has;

    // Is the request an express length, and does its bin hold a credit.
    always_comb begin
        want_x = (req_len >= LW'(2)) && (req_len <= LW'(LMAX));
        x_has  = 1'b0;
        for (int k = 1; k < LMAX; k++) begin
            if (req_len == LW'(k + 1)) x_has = has[k];
        end
    end

    // Express first, normal fallback second, otherwise no launch.
    always_comb begin
        go     = 1'b0;
        go_len = '0;
        go_x   = 1'b0;
        if (req_valid && alloc_ok) begin
            if (want_x && !blocked && x_has) begin
                go     = 1'b1;
                go_len = req_len;
                go_x   = 1'b1;
            end else if (has[0]) begin
                go     = 1'b1;
                go_len = LW'(1);
            end
        end
    end

    // One-hot credit consumption for the granted bin.
    always_comb begin
        for (int k = 0; k < LMAX; k++) begin
            take[k] = go && (go_len == LW'(k + 1));
        end
    end
endmodule

// File: rtl/xvc_launch_gate.sv
// Module: express channel source launch gate (top).
// Holds per-length credit bins, the starvation window and registered outputs.
// Assumes alloc_ok already reflects won VC and switch allocation.
module xvc_launch_gate #(
    parameter  int LMAX       = 4,
    parameter  int BASE_DEPTH = 2,
    parameter  int BLOCK_CYC  = 6,
    localparam int LW         = $clog2(LMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [LW-1:0]   req_len,
    input  logic            alloc_ok,
    input  logic [LMAX-1:0] crd_ret,
    input  logic            starve_tok,
    output logic            grant,
    output logic [LW-1:0]   grant_len,
    output logic            lookahead
);
    localparam int MAXD = BASE_DEPTH + LMAX - 1;
    localparam int CW   = $clog2(MAXD + 1);
    localparam int PW   = $clog2(BLOCK_CYC + 1);

    logic [LMAX-1:0]    has;
    logic [LMAX-1:0]    take;
    logic [LMAX*CW-1:0] cnt_flat;
    logic               blocked;
    logic               go;
    logic               go_x;
    logic [LW-1:0]      go_len;

    // One credit bin per hop length, depth shrinking with length.
    for (genvar k = 0; k < LMAX; k++) begin : g_bin
        xvc_credit_bin #(
            .DEPTH (xvc_pkg::bin_depth(k + 1, LMAX, BASE_DEPTH)),
            .CW    (CW)
        ) u_bin (
            .clk        (clk),
            .rst_n      (rst_n),
            .ret        (crd_ret[k]),
            .take       (take[k]),
            .cnt        (cnt_flat[k*CW +: CW]),
            .has_credit (has[k])
        );
    end

    xvc_block_timer #(.P(BLOCK_CYC), .PW(PW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tok     (starve_tok),
        .blocked (blocked)
    );

    xvc_pick #(.LMAX(LMAX), .LW(LW)) u_pick (
        .req_valid (req_valid),
        .alloc_ok  (alloc_ok),
        .req_len   (req_len),
        .has       (has),
        .blocked   (blocked),
        .go        (go),
        .go_len    (go_len),
        .go_x      (go_x),
        .take      (take)
    );

    // Register the decision so outputs leave from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant     <= 1'b0;
            grant_len <= '0;
            lookahead <= 1'b0;
        end else begin
            grant     <= go;
            grant_len <= go_len;
            lookahead <= go_x;
        end
    end
endmodule

// File: rtl/xvc_launch_gate_chk.sv
// Module: property checker for the launch gate, bound to the top.
// Keeps its own copy of the starvation window to judge the strobe.
module xvc_launch_gate_chk #(
    parameter int LMAX       = 4,
    parameter int BASE_DEPTH = 2,
    parameter int BLOCK_CYC  = 6,
    parameter int LW         = 3,
    parameter int CW         = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               alloc_ok,
    input logic [LMAX-1:0]    crd_ret,
    input logic               starve_tok,
    input logic               grant,
    input logic [LW-1:0]      grant_len,
    input logic               lookahead,
    input logic [LMAX*CW-1:0] cnt_flat,
    input logic [LMAX-1:0]    take
);
    int win;

    // Independent window counter, loaded by each token.
    always_ff @(posedge clk) begin
        if (!rst_n)          win <= 0;
        else if (starve_tok) win <= BLOCK_CYC;
        else if (win != 0)   win <= win - 1;
    end

    // R2
    no_unasked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && alloc_ok) |=> !grant);

    // R8
    blocked_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (starve_tok || win != 0) |=> !lookahead);

    // R10
    strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookahead == (grant && grant_len > LW'(1)));

    for (genvar k = 0; k < LMAX; k++) begin : g_bin_chk
        // R7
        depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_flat[k*CW +: CW]) <= xvc_pkg::bin_depth(k + 1, LMAX, BASE_DEPTH));
        // R7
        ret_take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (crd_ret[k] && take[k]) |=> cnt_flat[k*CW +: CW] == $past(cnt_flat[k*CW +: CW]));
        // R6
        empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[k*CW +: CW] == '0) |=> !(grant && grant_len == LW'(k + 1)));
    end
endmodule

bind xvc_launch_gate xvc_launch_gate_chk #(
    .LMAX       (LMAX),
    .BASE_DEPTH (BASE_DEPTH),
    .BLOCK_CYC  (BLOCK_CYC),
    .LW         (LW),
    .CW         (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .alloc_ok   (alloc_ok),
    .crd_ret    (crd_ret),
    .starve_tok (starve_tok),
    .grant      (grant),
    .grant_len  (grant_len),
    .lookahead  (lookahead),
    .cnt_flat   (cnt_flat),
    .take       (take)
);

// File: tb/xvc_launch_gate_bench.sv
`timescale 1ns/100ps
// Bench: directed corners plus seeded random traffic against a bench model.
module xvc_launch_gate_bench;
    localparam int LMAX = 4;
    localparam int BASE = 2;
    localparam int P    = 6;
    localparam int LW   = $clog2(LMAX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [LW-1:0]   req_len = '0;
    logic            alloc_ok = 1'b0;
    logic [LMAX-1:0] crd_ret = '0;
    logic            starve_tok = 1'b0;
    logic            grant;
    logic [LW-1:0]   grant_len;
    logic            lookahead;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mcred[LMAX];
    int mblk;

    always #2.5 clk = ~clk;

    xvc_launch_gate #(.LMAX(LMAX), .BASE_DEPTH(BASE), .BLOCK_CYC(P)) u_xvc_launch_gate (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_len (req_len),
        .alloc_ok (alloc_ok), .crd_ret (crd_ret), .starve_tok (starve_tok),
        .grant (grant), .grant_len (grant_len), .lookahead (lookahead)
    );

    // Depth of a bin from R1, written independently of the RTL.
    function automatic int depth_of(input int hop);
        return BASE + LMAX - hop;
    endfunction

    task automatic compare(input string tag, input int eg, input int el, input int ex);
        checks++;
        if (int'(grant) != eg || int'(grant_len) != el || int'(lookahead) != ex) begin
            fails++;
            $display("FAIL %s: grant=%0d len=%0d la=%0d expected grant=%0d len=%0d la=%0d",
                     tag, grant, grant_len, lookahead, eg, el, ex);
        end
    endtask

    // Apply one request cycle, predict from the model, then check after the edge.
    task automatic apply(input bit v, input bit ok, input int len, input int ret,
                         input bit tok, input string tag);
        int  eg, el, ex;
        bit  blk, wx;
        string t;
        @(negedge clk);
        req_valid = v; alloc_ok = ok; req_len = LW'(len);
        crd_ret = LMAX'(ret); starve_tok = tok;
        blk = tok || (mblk != 0);
        wx  = (len >= 2) && (len <= LMAX);
        eg = 0; el = 0; ex = 0;
        if (v && ok) begin
            if (wx && !blk && mcred[len-1] > 0) begin eg = 1; el = len; ex = 1; end
            else if (mcred[0] > 0) begin eg = 1; el = 1; end
        end
        t = tag;
        if (t == "") begin
            if (!(v && ok))   t = "R2";
            else if (wx && blk) t = "R8";
            else if (ex == 1) t = "R3";
            else if (wx)      t = "R4";
            else if (eg == 1) t = "R5";
            else              t = "R6";
        end
        for (int k = 0; k < LMAX; k++) begin
            bit tk, rt;
            tk = (eg == 1) && (el == k + 1);
            rt = ret[k];
            if (rt && !tk && mcred[k] < depth_of(k + 1)) mcred[k]++;
            else if (tk && !rt) mcred[k]--;
        end
        if (tok) mblk = P;
        else if (mblk > 0) mblk--;
        @(posedge clk);
        #1;
        compare(t, eg, el, ex);
    endtask

    initial begin
        for (int k = 0; k < LMAX; k++) mcred[k] = depth_of(k + 1);
        mblk = 0;
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        compare("R1", 0, 0, 0);

        // R6: drain the length-3 bin (depth 3); the fourth falls back to normal.
        for (int i = 0; i < 4; i++) apply(1, 1, 3, 0, 0, "R6");
        // R7: saturate all bins, then length 4 (depth 2) grants only twice.
        for (int i = 0; i < 5; i++) apply(0, 0, 0, 4'hF, 0, "R7");
        for (int i = 0; i < 3; i++) apply(1, 1, 4, 0, 0, "R7");
        // R7: return and launch together on length 2 keep it granting.
        for (int i = 0; i < 8; i++) apply(1, 1, 2, 4'b0010, 0, "R7");
        // R8: token blocks its own cycle and the next P, then express resumes.
        apply(1, 1, 2, 4'b0011, 1, "R8");
        for (int i = 0; i < P; i++) apply(1, 1, 2, 4'b0011, 0, "R8");
        apply(1, 1, 2, 4'b0011, 0, "R8");
        // R9: a second token mid-window restarts the full window.
        apply(1, 1, 2, 4'b0011, 1, "R9");
        for (int i = 0; i < 3; i++) apply(1, 1, 2, 4'b0011, 0, "R9");
        apply(1, 1, 2, 4'b0011, 1, "R9");
        for (int i = 0; i < P; i++) apply(1, 1, 2, 4'b0011, 0, "R9");
        apply(1, 1, 2, 4'b0011, 0, "R9");
        // R5: out-of-range lengths act as normal requests.
        apply(1, 1, 0, 4'b0001, 0, "R5");
        apply(1, 1, 7, 4'b0001, 0, "R5");
        apply(1, 1, 1, 4'b0001, 0, "R5");
        // R2: allocation not won or no request yields no grant.
        apply(1, 0, 2, 0, 0, "R2");
        apply(0, 1, 2, 0, 0, "R2");
        // R6: drain the normal bin; once empty nothing is granted.
        for (int i = 0; i < 7; i++) apply(1, 1, 1, 0, 0, "R6");
        // R10: express launches each carry the strobe (random traffic).
        for (int i = 0; i < 3000; i++) begin
            int len, ret;
            bit v, ok, tok;
            v   = ($urandom % 8) != 0;
            ok  = ($urandom % 6) != 0;
            len = $urandom % 8;
            ret = 0;
            for (int k = 0; k < LMAX; k++) if (($urandom % 5) < 2) ret |= (1 << k);
            tok = ($urandom % 40) == 0;
            apply(v, ok, len, ret, tok, (i % 10 == 0) ? "R10" : "");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule